// File: doc/BRIEF.md
# Prioritized Multi-Level Interrupt Controller

The block keeps a set of interrupt levels. Each level has a four-state lifecycle (disarmed, armed, waiting, active) and an enable flag. A level may also belong to one of three inhibit groups. An armed level that receives a request becomes waiting. While the processor reports that it is at an interruptible point, the controller grants the most urgent waiting level that is enabled and not inhibited. The grant is held back if a more urgent level is already active. The granted level becomes active once the processor acknowledges that it has fetched the interrupt instruction.

A waiting level that is disabled, or whose group is inhibited, drops out of the priority chain. It does not hold back less urgent levels. Software-style commands reach the block as a strobe, an opcode and a level-select mask. The commands arm, disarm, enable, disable or clear levels, or force a waiting level straight to active. The per-level states and enable flags are brought out so the surrounding logic can inspect them.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every level reads disarmed, every enable flag is clear and `grant_vld_o` is low.
- R2: `lvl_state_o[2i+1:2i]` encodes level i as 0 = disarmed, 1 = armed, 2 = waiting, 3 = active. Opcode 1 (arm) moves each selected non-active level to armed. Opcode 2 (disarm) moves each selected level to disarmed.
- R3: A request on an armed level makes it waiting on the next cycle. A request on a level in any other state is ignored.
- R4: A level is eligible when it is waiting, enabled, and its group inhibit bit is clear. Group g uses bit g-1 of `grp_inh_i`. Level i sits in group i mod 4, and group 0 means no group. No grant is issued while `intr_pt_i` is low.
- R5: In the same cycle, the grant names the lowest-index eligible level, but only if no level of lower index is active. Lower index means higher priority.
- R6: A waiting level that is disabled or inhibited never blocks a lower-priority eligible level.
- R7: With `ack_i` high while a grant is valid, the granted level becomes active on the next cycle. Without `ack_i`, the level stays waiting.
- R8: Opcode 5 (clear) returns each selected active level to armed. An active level leaves active only through a command.
- R9: Opcode 6 (force) moves each selected waiting level to active, whatever its enable, inhibit or priority.
- R10: A disabled level still takes every other state change: arm, disarm, request, clear and force.
- R11: Opcodes 3 and 4 set and clear the selected enable flags and leave the states alone. For a selected level, a state-changing command takes precedence over acknowledge and request. Nothing changes while `cmd_vld_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_LVL | Per-level request |
| grp_inh_i | input | N_GRP | Per-group inhibit bits |
| intr_pt_i | input | 1 | Processor is at an interruptible point |
| ack_i | input | 1 | Interrupt instruction fetched for the granted level |
| cmd_vld_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command opcode |
| cmd_sel_i | input | N_LVL | Level-select mask for the command |
| grant_vld_o | output | 1 | A level is granted this cycle |
| grant_idx_o | output | IW | Index of the granted level (0 when none) |
| lvl_state_o | output | 2*N_LVL | Per-level state, two bits each |
| lvl_en_o | output | N_LVL | Per-level enable flags |

## Verification
The grant is tried with a disabled level above an enabled one, and with an inhibited group above a free one. These two patterns separate removal from the chain from blocking. Nested cases put an active level above a waiting one and then below it, which shows whether an active level gates only the levels under it. A long seeded random run mixes commands, requests, inhibits and acknowledges against a per-cycle reference model. That run exposes wrong precedence between a command, an acknowledge and a request aimed at the same level in the same cycle.

// File: rtl/prio_irq_pkg.sv
`timescale 1ns/1ps
package prio_irq_pkg;
  typedef enum logic [1:0] {
    LV_IDLE  = 2'd0,
    LV_ARMED = 2'd1,
    LV_PEND  = 2'd2,
    LV_ACT   = 2'd3
  } lvl_st_e;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_ARM    = 3'd1,
    OP_DISARM = 3'd2,
    OP_EN     = 3'd3,
    OP_DIS    = 3'd4,
    OP_CLR    = 3'd5,
    OP_FORCE  = 3'd6,
    OP_RSV    = 3'd7
  } cmd_op_e;
endpackage

// File: rtl/prio_irq_lvl.sv
`timescale 1ns/1ps
module prio_irq_lvl
  import prio_irq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_i,
  input  logic    cmd_hit_i,
  input  cmd_op_e cmd_op_i,
  input  logic    take_i,
  output lvl_st_e st_o,
  output logic    en_o
);
  lvl_st_e st_q, st_d;
  logic    en_q, en_d;
  logic    st_cmd;

  always_comb begin
    st_cmd = cmd_hit_i && (cmd_op_i == OP_ARM || cmd_op_i == OP_DISARM ||
                           cmd_op_i == OP_CLR || cmd_op_i == OP_FORCE);
    st_d = st_q;
    if (st_cmd) begin
      unique case (cmd_op_i)
        OP_ARM:    if (st_q != LV_ACT) st_d = LV_ARMED;
        OP_DISARM: st_d = LV_IDLE;
        OP_CLR:    if (st_q == LV_ACT) st_d = LV_ARMED;
        OP_FORCE:  if (st_q == LV_PEND) st_d = LV_ACT;
        default:   st_d = st_q;
      endcase
    end else if (take_i) begin
      st_d = LV_ACT;
    end else if (req_i && st_q == LV_ARMED) begin
      st_d = LV_PEND;
    end
  end

  always_comb begin
    en_d = en_q;
    if (cmd_hit_i && cmd_op_i == OP_EN)  en_d = 1'b1;
    if (cmd_hit_i && cmd_op_i == OP_DIS) en_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= LV_IDLE;
      en_q <= 1'b0;
    end else begin
      st_q <= st_d;
      en_q <= en_d;
    end
  end

  assign st_o = st_q;
  assign en_o = en_q;

  // R7
  pend_to_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == LV_PEND && !take_i && !(cmd_hit_i && cmd_op_i == OP_FORCE)) |=> st_q != LV_ACT);
  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == LV_IDLE && !cmd_hit_i) |=> st_q == LV_IDLE);
  // R8
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == LV_ACT && !cmd_hit_i) |=> st_q == LV_ACT);
  // R11
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_hit_i && (cmd_op_i == OP_EN || cmd_op_i == OP_DIS)) |=> $stable(en_q));
endmodule

// File: rtl/prio_irq_arb.sv
`timescale 1ns/1ps
module prio_irq_arb #(
  parameter int N_LVL = 8,
  localparam int IW   = (N_LVL > 1) ? $clog2(N_LVL) : 1
) (
  input  logic [N_LVL-1:0] elig_i,
  input  logic [N_LVL-1:0] act_i,
  input  logic             open_i,
  input  logic             ack_i,
  output logic             grant_vld_o,
  output logic [IW-1:0]    grant_idx_o,
  output logic [N_LVL-1:0] take_o
);
  logic          hit;
  logic          gv;
  logic [IW-1:0] gi;

  // first active-or-eligible level from the top wins; an active one blocks the rest
  always_comb begin
    hit = 1'b0;
    gv  = 1'b0;
    gi  = '0;
    for (int i = 0; i < N_LVL; i++) begin
      if (!hit && (act_i[i] || elig_i[i])) begin
        hit = 1'b1;
        gv  = elig_i[i] && !act_i[i];
        gi  = IW'(i);
      end
    end
    if (!open_i) gv = 1'b0;
    if (!gv) gi = '0;
  end

  assign grant_vld_o = gv;
  assign grant_idx_o = gi;
  assign take_o      = (ack_i && gv) ? (N_LVL'(1) << gi) : '0;
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int N_LVL = 8,
  parameter int N_GRP = 3,
  localparam int GW   = $clog2(N_GRP + 1),
  localparam int IW   = (N_LVL > 1) ? $clog2(N_LVL) : 1,
  // per level: GW-bit group number, 0 = ungrouped
  parameter logic [GW*N_LVL-1:0] GRP_MAP = 16'hE4E4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LVL-1:0]   req_i,
  input  logic [N_GRP-1:0]   grp_inh_i,
  input  logic               intr_pt_i,
  input  logic               ack_i,
  input  logic               cmd_vld_i,
  input  logic [2:0]         cmd_op_i,
  input  logic [N_LVL-1:0]   cmd_sel_i,
  output logic               grant_vld_o,
  output logic [IW-1:0]      grant_idx_o,
  output logic [2*N_LVL-1:0] lvl_state_o,
  output logic [N_LVL-1:0]   lvl_en_o
);
  cmd_op_e           op;
  lvl_st_e           st_w [N_LVL];
  logic [N_LVL-1:0]  en_w;
  logic [N_LVL-1:0]  inh_w;
  logic [N_LVL-1:0]  elig_w;
  logic [N_LVL-1:0]  act_w;
  logic [N_LVL-1:0]  take_w;

  assign op = cmd_op_e'(cmd_op_i);

  for (genvar i = 0; i < N_LVL; i++) begin : g_lvl
    localparam int GRP = int'(GRP_MAP[GW*i +: GW]);

    if (GRP == 0 || GRP > N_GRP) begin : g_free
      assign inh_w[i] = 1'b0;
    end else begin : g_grp
      assign inh_w[i] = grp_inh_i[GRP-1];
    end

    prio_irq_lvl u_lvl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_i     (req_i[i]),
      .cmd_hit_i (cmd_vld_i && cmd_sel_i[i]),
      .cmd_op_i  (op),
      .take_i    (take_w[i]),
      .st_o      (st_w[i]),
      .en_o      (en_w[i])
    );

    assign elig_w[i] = (st_w[i] == LV_PEND) && en_w[i] && !inh_w[i];
    assign act_w[i]  = (st_w[i] == LV_ACT);
    assign lvl_state_o[2*i +: 2] = st_w[i];
  end

  assign lvl_en_o = en_w;

  prio_irq_arb #(.N_LVL(N_LVL)) u_arb (
    .elig_i      (elig_w),
    .act_i       (act_w),
    .open_i      (intr_pt_i),
    .ack_i       (ack_i),
    .grant_vld_o (grant_vld_o),
    .grant_idx_o (grant_idx_o),
    .take_o      (take_w)
  );

  // R4
  grant_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_vld_o |-> intr_pt_i);
  // R4
  grant_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_vld_o |-> (lvl_state_o[2*grant_idx_o +: 2] == 2'd2 && lvl_en_o[grant_idx_o]));
  // R5
  grant_nest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_vld_o |-> ((act_w & ((N_LVL'(1) << grant_idx_o) - N_LVL'(1))) == '0));
  // R7
  take_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(take_w));
endmodule

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
  localparam int N  = 8;
  localparam int NG = 3;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic [NG-1:0] inh = '0;
  logic          ipt = 1'b0;
  logic          ack = 1'b0;
  logic          cvld = 1'b0;
  logic [2:0]    cop = 3'd0;
  logic [N-1:0]  csel = '0;
  logic          grant_vld_o;
  logic [IW-1:0] grant_idx_o;
  logic [2*N-1:0] lvl_state_o;
  logic [N-1:0]  lvl_en_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int m_st [N];
  bit m_en [N];

  always #2.5 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .grp_inh_i(inh), .intr_pt_i(ipt),
    .ack_i(ack), .cmd_vld_i(cvld), .cmd_op_i(cop), .cmd_sel_i(csel),
    .grant_vld_o(grant_vld_o), .grant_idx_o(grant_idx_o),
    .lvl_state_o(lvl_state_o), .lvl_en_o(lvl_en_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic bit inhibited(input int i);
    int g = i % 4;
    return (g != 0) && inh[g-1];
  endfunction

  function automatic void exp_grant(output bit gv, output int gi);
    gv = 0; gi = 0;
    for (int i = 0; i < N; i++) begin
      if (m_st[i] == 3) return;
      if (m_st[i] == 2 && m_en[i] && !inhibited(i)) begin
        gv = ipt; gi = ipt ? i : 0;
        return;
      end
    end
  endfunction

  function automatic void model_step(input bit gv, input int gi);
    for (int i = 0; i < N; i++) begin
      bit hit = cvld && csel[i];
      if (hit && cop == 3'd1) begin
        if (m_st[i] != 3) m_st[i] = 1;
      end else if (hit && cop == 3'd2) m_st[i] = 0;
      else if (hit && cop == 3'd5) begin
        if (m_st[i] == 3) m_st[i] = 1;
      end else if (hit && cop == 3'd6) begin
        if (m_st[i] == 2) m_st[i] = 3;
      end else if (ack && gv && gi == i) m_st[i] = 3;
      else if (req[i] && m_st[i] == 1) m_st[i] = 2;
      if (hit && cop == 3'd3) m_en[i] = 1;
      if (hit && cop == 3'd4) m_en[i] = 0;
    end
  endfunction

  task automatic cycle(input string tag);
    bit egv;
    int egi;
    logic [2*N-1:0] es;
    logic [N-1:0] ee;
    #1;
    exp_grant(egv, egi);
    chk({tag, " grant_vld"}, int'(grant_vld_o), int'(egv));
    if (egv) chk({tag, " grant_idx"}, int'(grant_idx_o), egi);
    model_step(egv, egi);
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      es[2*i +: 2] = 2'(m_st[i]);
      ee[i] = m_en[i];
    end
    chk({tag, " state"}, int'(lvl_state_o), int'(es));
    chk({tag, " enable"}, int'(lvl_en_o), int'(ee));
  endtask

  task automatic cmd(input logic [2:0] o, input logic [N-1:0] s);
    cvld = 1'b1; cop = o; csel = s;
  endtask

  task automatic idle_in();
    cvld = 1'b0; cop = 3'd0; csel = '0; req = '0; ack = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < N; i++) begin m_st[i] = 0; m_en[i] = 0; end
    #7;
    // R1
    chk("R1 state", int'(lvl_state_o), 0);
    chk("R1 enable", int'(lvl_en_o), 0);
    chk("R1 grant", int'(grant_vld_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    ipt = 1'b1;
    // R3: request on disarmed levels ignored
    req = '1; cycle("R3"); idle_in();
    // R2: arm all
    cmd(3'd1, '1); cycle("R2"); idle_in();
    // R10: disabled levels take requests
    req = 8'b0010_0010; cycle("R10"); idle_in();
    // R11: enable only level 5, state untouched
    cmd(3'd3, 8'b0010_0000); cycle("R11"); idle_in();
    // R6: disabled waiting level 1 does not block level 5
    cycle("R6");
    // R4: not at interruptible point
    ipt = 1'b0; cycle("R4"); ipt = 1'b1;
    // R4: level 5 in group 1 inhibited
    inh = 3'b001; cycle("R4");
    // R6: inhibited level 5 does not block level 6
    cmd(3'd3, 8'b0100_0000); cycle("R6"); idle_in();
    req = 8'b0100_0000; cycle("R6"); idle_in();
    cycle("R6");
    inh = '0;
    // R5: enable level 1 -> highest priority wins
    cmd(3'd3, 8'b0000_0010); cycle("R5"); idle_in();
    cycle("R5");
    // R7: ack activates granted level
    ack = 1'b1; cycle("R7"); idle_in();
    // R5: active level 1 blocks lower ones
    cycle("R5");
    // R11: disarm wins over ack on granted level
    cmd(3'd1, 8'b0000_0001); cycle("R2"); idle_in();
    req = 8'b0000_0001; cycle("R3"); idle_in();
    cmd(3'd3, 8'b0000_0001); cycle("R11"); idle_in();
    cycle("R5");
    ack = 1'b1; cmd(3'd2, 8'b0000_0001); cycle("R11"); idle_in();
    // R8: clear level 1
    cmd(3'd5, 8'b0000_0010); cycle("R8"); idle_in();
    cycle("R5");
    // R9: force disabled, lower-priority level 6 while 5 waits
    cmd(3'd4, 8'b0100_0000); cycle("R11"); idle_in();
    cmd(3'd6, 8'b0100_0000); cycle("R9"); idle_in();
    cycle("R5");
    // R11: no effect without strobe
    cop = 3'd2; csel = '1; cycle("R11"); idle_in();
    // randomized phase
    for (int k = 0; k < 4000; k++) begin
      cvld = ($urandom % 10) < 3;
      cop  = 3'($urandom % 7);
      csel = N'($urandom & $urandom);
      req  = N'($urandom & $urandom);
      inh  = NG'($urandom & $urandom);
      ipt  = ($urandom % 10) < 7;
      ack  = $urandom % 2;
      cycle("R5");
    end
    idle_in();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule